// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Page Invalidation

This block holds recently used linear-to-physical page translations in a direct-mapped array. Each slot keeps a 4 KB-aligned linear frame, a 4 KB-aligned physical frame, a 32-bit access word and a page-size mask. The mask is 0xFFF for a 4 KB page and has more low bits set for a larger page. A requester issues one operation per cycle on a single request port: lookup, fill, flush-all, flush-non-global or single-page invalidate. Lookups return a registered response one cycle later.

The whole-array operations (flush-all, flush-non-global, and invalidate while large pages may be present) run on a sweep engine that visits one slot per cycle and raises `busy` for the whole walk. The engine keeps a sticky "large page present" flag. A fill with a mask above 0xFFF sets the flag. While the flag is clear, an invalidate only checks one slot and completes in a single cycle. While it is set, the invalidate becomes a masked sweep over every slot. Each sweep that can keep entries rebuilds the flag from the masks of the entries it leaves valid.

The sweep controller has four states. ST_IDLE accepts requests. ST_CLR_ALL, ST_CLR_LOCAL and ST_INV_SCAN are the sweep states for flush-all, flush-non-global and the masked invalidate. The transitions are: IDLE→CLR_ALL on an accepted flush-all; IDLE→CLR_LOCAL on an accepted flush-non-global; IDLE→INV_SCAN on an accepted invalidate while the flag is set; each sweep state→IDLE after it visits the last slot. Every other case stays in the current state.

Top module: `tlb_dm`

## Requirements
- R1: The slot index is bits [12+log2(ENTRIES)-1:12] of `req_laddr + req_len`. The sum is taken at the linear-address width, so an access that runs past its page selects the next slot. ENTRIES must be a power of two.
- R2: A fill (op code 1) writes the slot chosen by R1 and replaces whatever that slot held. It stores the linear frame as `req_laddr` with its low 12 bits cleared, the physical frame as `req_ppf` with its low 12 bits cleared, and `req_access` and `req_mask` unchanged.
- R3: A lookup (op code 0) is answered on the cycle after acceptance with `rsp_valid`=1. It hits when the indexed slot is valid and the request address equals the stored frame in every bit outside that slot's mask. On a hit, `rsp_paddr` = (physical frame & ~mask) | (address & mask) and `rsp_access` is the stored access word. On a miss, `rsp_hit`, `rsp_paddr` and `rsp_access` are 0.
- R4: The access word is stored and returned as given. Bit 2 means supervisor write allowed, bit 3 user write allowed, bit 4 supervisor execute allowed and bit 5 user execute allowed. Bit 31 marks a global page, and only bit 31 changes the block's behaviour.
- R5: A fill whose mask has any bit above bit 11 set raises `large_pg` on the next cycle. Lookups, fills of 4 KB pages and single-slot invalidates never clear it.
- R6: Flush-all (op code 2) invalidates every slot, and `large_pg` reads 0 once `busy` falls.
- R7: Flush-non-global (op code 3) invalidates every valid slot whose access bit 31 is 0. Once `busy` falls, `large_pg` is 1 exactly when the OR of the masks of the surviving global slots exceeds 0xFFF.
- R8: An invalidate (op code 4) accepted while `large_pg`=1 sweeps every slot. It invalidates each valid slot whose stored frame equals the address in all bits outside that slot's mask. It then sets `large_pg` from the OR of the masks of the slots that remain valid, using the same greater-than-0xFFF rule.
- R9: An invalidate accepted while `large_pg`=0 raises no `busy`. It checks only the slot indexed with length 0, invalidates it if its stored frame equals the address in bits [LA_W-1:12], and has taken effect by the next cycle.
- R10: After a sweep operation is accepted, `busy` is high for exactly ENTRIES cycles, and any new `large_pg` value is visible in the first cycle with `busy` low.
- R11: A request presented while `busy` is high is not accepted. It produces no response and changes no slot. Op codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 lookup, 1 fill, 2 flush-all, 3 flush-non-global, 4 invalidate page |
| req_laddr | input | LA_W | Linear address of lookup, fill or invalidate |
| req_len | input | LEN_W | Access length added before indexing |
| req_ppf | input | PA_W | Physical address for a fill |
| req_access | input | 32 | Access word for a fill |
| req_mask | input | LA_W | Page-size mask for a fill (0xFFF or wider, contiguous low ones) |
| busy | output | 1 | Sweep in progress; requests are not accepted |
| large_pg | output | 1 | Sticky large-page-present flag |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_access | output | 32 | Access word of the hit slot |

## Verification
The assertions assume that the requester never presents an op it expects to be served while `busy` is high, and that every fill mask is a run of low ones of at least twelve bits. The stimulus drives requests only on falling edges and waits for `busy` to drop before issuing the next operation, except in the scenario that tests R11 on purpose. Every mask it uses is 0xFFF or 0x3FFFFF. The checks compare each lookup with a slot model built from the requirements on a 16-slot configuration, which lets every slot be filled, looked up and swept.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int ACC_W      = 32;
    localparam int GLOBAL_BIT = 31;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_FILL      = 3'd1,
        OP_FLUSH_ALL = 3'd2,
        OP_FLUSH_NG  = 3'd3,
        OP_INV_PAGE  = 3'd4
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CLR_ALL   = 2'd1,
        ST_CLR_LOCAL = 2'd2,
        ST_INV_SCAN  = 2'd3
    } sweep_st_e;

endpackage

// File: rtl/tlb_index.sv
module tlb_index
    import tlb_pkg::*;
#(
    parameter int LA_W  = 32,
    parameter int LEN_W = 4,
    parameter int IDX_W = 10
) (
    input  logic [LA_W-1:0]  laddr,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] idx
);
    logic [LA_W-1:0] sum;

    always_comb begin
        sum = laddr + LA_W'(len);
        idx = sum[PAGE_SHIFT +: IDX_W];
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int LA_W  = 32,
    parameter bit SIZED = 1'b1
) (
    input  logic            ent_valid,
    input  logic [LA_W-1:0] ent_lpf,
    input  logic [LA_W-1:0] ent_mask,
    input  logic [LA_W-1:0] addr,
    output logic            hit
);
    generate
        if (SIZED) begin : g_sized
            always_comb hit = ent_valid && ((addr & ~ent_mask) == (ent_lpf & ~ent_mask));
        end else begin : g_frame4k
            logic unused_mask;
            always_comb unused_mask = ^ent_mask;
            always_comb hit = ent_valid &&
                (addr[LA_W-1:PAGE_SHIFT] == ent_lpf[LA_W-1:PAGE_SHIFT]);
        end
    endgenerate
endmodule

// File: rtl/tlb_sweep_fsm.sv
module tlb_sweep_fsm
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int LA_W    = 32,
    parameter int IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_all,
    input  logic             go_local,
    input  logic             go_inv,
    input  logic             ent_valid,
    input  logic             ent_global,
    input  logic [LA_W-1:0]  ent_mask,
    input  logic             ent_hit,
    output logic             busy,
    output logic [IDX_W-1:0] scan_idx,
    output logic             kill,
    output logic             flag_wr,
    output logic             flag_val
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    sweep_st_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [LA_W-1:0]  acc_q, acc_d;
    logic             survive;
    logic             at_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            acc_q   <= acc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        acc_d   = acc_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                acc_d = '0;
                if (go_all)        state_d = ST_CLR_ALL;
                else if (go_local) state_d = ST_CLR_LOCAL;
                else if (go_inv)   state_d = ST_INV_SCAN;
            end
            ST_CLR_ALL, ST_CLR_LOCAL, ST_INV_SCAN: begin
                acc_d = acc_q | (survive ? ent_mask : '0);
                idx_d = idx_q + 1'b1;
                if (at_last) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        at_last  = (idx_q == LAST_IDX);
        busy     = (state_q != ST_IDLE);
        scan_idx = idx_q;
        kill     = 1'b0;
        survive  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CLR_ALL:   kill = ent_valid;
            ST_CLR_LOCAL: begin
                kill    = ent_valid && !ent_global;
                survive = ent_valid &&  ent_global;
            end
            ST_INV_SCAN: begin
                kill    = ent_valid &&  ent_hit;
                survive = ent_valid && !ent_hit;
            end
        endcase
        flag_wr  = busy && at_last;
        flag_val = (state_q != ST_CLR_ALL) &&
                   (|(acc_q[LA_W-1:PAGE_SHIFT] | (survive ? ent_mask[LA_W-1:PAGE_SHIFT] : '0)));
    end
endmodule

// File: rtl/tlb_dm.sv
module tlb_dm
    import tlb_pkg::*;
#(
    parameter int LA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 1024,
    parameter int LEN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [LA_W-1:0]   req_laddr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [PA_W-1:0]   req_ppf,
    input  logic [ACC_W-1:0]  req_access,
    input  logic [LA_W-1:0]   req_mask,
    output logic              busy,
    output logic              large_pg,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ACC_W-1:0]  rsp_access
);
    localparam int IDX_W = $clog2(ENTRIES);

    // entry storage
    logic [ENTRIES-1:0] vld_q;
    logic [LA_W-1:0]    lpf_q [ENTRIES];
    logic [PA_W-1:0]    ppf_q [ENTRIES];
    logic [ACC_W-1:0]   acc_q [ENTRIES];
    logic [LA_W-1:0]    msk_q [ENTRIES];

    logic             flag_q;
    logic [LA_W-1:0]  inv_addr_q;

    logic [IDX_W-1:0] req_idx, probe_idx, scan_idx;
    logic             req_hit, probe_hit, scan_hit;
    logic             accept, do_lookup, do_fill, do_inv;
    logic             go_all, go_local, go_inv, probe_kill;
    logic             sw_busy, sw_kill, flag_wr, flag_val;
    tlb_op_e          op;

    always_comb begin
        op         = tlb_op_e'(req_op);
        accept     = req_valid && !sw_busy;
        do_lookup  = accept && (op == OP_LOOKUP);
        do_fill    = accept && (op == OP_FILL);
        do_inv     = accept && (op == OP_INV_PAGE);
        go_all     = accept && (op == OP_FLUSH_ALL);
        go_local   = accept && (op == OP_FLUSH_NG);
        go_inv     = do_inv &&  flag_q;
        probe_kill = do_inv && !flag_q && probe_hit;
    end

    tlb_index #(.LA_W(LA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_idx_req (
        .laddr (req_laddr),
        .len   (req_len),
        .idx   (req_idx)
    );

    tlb_index #(.LA_W(LA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_idx_probe (
        .laddr (req_laddr),
        .len   ('0),
        .idx   (probe_idx)
    );

    tlb_match #(.LA_W(LA_W), .SIZED(1'b1)) u_match_req (
        .ent_valid (vld_q[req_idx]),
        .ent_lpf   (lpf_q[req_idx]),
        .ent_mask  (msk_q[req_idx]),
        .addr      (req_laddr),
        .hit       (req_hit)
    );

    tlb_match #(.LA_W(LA_W), .SIZED(1'b0)) u_match_probe (
        .ent_valid (vld_q[probe_idx]),
        .ent_lpf   (lpf_q[probe_idx]),
        .ent_mask  (msk_q[probe_idx]),
        .addr      (req_laddr),
        .hit       (probe_hit)
    );

    tlb_match #(.LA_W(LA_W), .SIZED(1'b1)) u_match_scan (
        .ent_valid (vld_q[scan_idx]),
        .ent_lpf   (lpf_q[scan_idx]),
        .ent_mask  (msk_q[scan_idx]),
        .addr      (inv_addr_q),
        .hit       (scan_hit)
    );

    tlb_sweep_fsm #(.ENTRIES(ENTRIES), .LA_W(LA_W), .IDX_W(IDX_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_all     (go_all),
        .go_local   (go_local),
        .go_inv     (go_inv),
        .ent_valid  (vld_q[scan_idx]),
        .ent_global (acc_q[scan_idx][GLOBAL_BIT]),
        .ent_mask   (msk_q[scan_idx]),
        .ent_hit    (scan_hit),
        .busy       (sw_busy),
        .scan_idx   (scan_idx),
        .kill       (sw_kill),
        .flag_wr    (flag_wr),
        .flag_val   (flag_val)
    );

    // valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (do_fill)    vld_q[req_idx]   <= 1'b1;
            if (probe_kill) vld_q[probe_idx] <= 1'b0;
            if (sw_kill)    vld_q[scan_idx]  <= 1'b0;
        end
    end

    // payload fields
    always_ff @(posedge clk) begin
        if (do_fill) begin
            lpf_q[req_idx] <= {req_laddr[LA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            ppf_q[req_idx] <= {req_ppf[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            acc_q[req_idx] <= req_access;
            msk_q[req_idx] <= req_mask;
        end
    end

    // large-page flag and latched invalidate address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q     <= 1'b0;
            inv_addr_q <= '0;
        end else begin
            if (flag_wr)
                flag_q <= flag_val;
            else if (do_fill && (|req_mask[LA_W-1:PAGE_SHIFT]))
                flag_q <= 1'b1;
            if (do_inv)
                inv_addr_q <= req_laddr;
        end
    end

    // lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_paddr  <= '0;
            rsp_access <= '0;
        end else begin
            rsp_valid  <= do_lookup;
            rsp_hit    <= do_lookup && req_hit;
            if (do_lookup && req_hit) begin
                rsp_paddr  <= (ppf_q[req_idx] & ~PA_W'(msk_q[req_idx])) |
                              PA_W'(req_laddr & msk_q[req_idx]);
                rsp_access <= acc_q[req_idx];
            end else begin
                rsp_paddr  <= '0;
                rsp_access <= '0;
            end
        end
    end

    always_comb begin
        busy     = sw_busy;
        large_pg = flag_q;
    end
endmodule

// File: rtl/tlb_dm_chk.sv
module tlb_dm_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int LA_W    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [LA_W-1:0] req_mask,
    input logic            busy,
    input logic            large_pg,
    input logic            rsp_valid,
    input logic            rsp_hit
);
    localparam int CNT_W = $clog2(ENTRIES + 1) + 1;

    logic [CNT_W-1:0] run_len;
    logic             last_was_all;
    logic             acc_ok;

    always_comb acc_ok = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len      <= '0;
            last_was_all <= 1'b0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (acc_ok && (req_op == OP_FLUSH_ALL))
                last_was_all <= 1'b1;
            else if (acc_ok && ((req_op == OP_FLUSH_NG) || (req_op == OP_INV_PAGE)))
                last_was_all <= 1'b0;
        end
    end

    p_rsp_from_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !busy && (req_op == OP_LOOKUP)));

    p_hit_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    p_fill_large_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (req_op == OP_FILL) && (|req_mask[LA_W-1:PAGE_SHIFT])) |=> large_pg);

    p_sweep_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == CNT_W'(ENTRIES)));

    p_all_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && last_was_all) |-> !large_pg);

    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);
endmodule

bind tlb_dm tlb_dm_chk #(.ENTRIES(ENTRIES), .LA_W(LA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_mask  (req_mask),
    .busy      (busy),
    .large_pg  (large_pg),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit)
);

// File: tb/tlb_dm_tb.sv
module tlb_dm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam logic [31:0] GLB = 32'h8000_0000;
    localparam logic [31:0] M4K = 32'h0000_0FFF;
    localparam logic [31:0] M4M = 32'h003F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [31:0] req_laddr;
    logic [3:0]  req_len;
    logic [31:0] req_ppf;
    logic [31:0] req_access;
    logic [31:0] req_mask;
    logic        busy, large_pg, rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr, rsp_access;

    int n_tests = 0;
    int n_fail  = 0;

    // slot model
    bit          m_vld [N];
    logic [31:0] m_lpf [N];
    logic [31:0] m_ppf [N];
    logic [31:0] m_acc [N];
    logic [31:0] m_msk [N];
    bit          m_flag;
    logic [31:0] seen [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_dm #(.LA_W(32), .PA_W(32), .ENTRIES(N), .LEN_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_laddr(req_laddr), .req_len(req_len), .req_ppf(req_ppf),
        .req_access(req_access), .req_mask(req_mask), .busy(busy),
        .large_pg(large_pg), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_access(rsp_access)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [31:0] a, input logic [3:0] len);
        logic [31:0] s;
        s = a + {28'd0, len};
        return int'((s >> 12) & (N - 1));
    endfunction

    task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [3:0] len,
                         input logic [31:0] ppf, input logic [31:0] acc, input logic [31:0] msk);
        @(negedge clk);
        req_op = op; req_laddr = a; req_len = len; req_ppf = ppf;
        req_access = acc; req_mask = msk; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [31:0] a, input logic [3:0] len, input logic [31:0] ppf,
                        input logic [31:0] acc, input logic [31:0] msk);
        int i;
        i = slot_of(a, len);
        drive(3'd1, a, len, ppf, acc, msk);
        m_vld[i] = 1'b1; m_lpf[i] = a & ~M4K; m_ppf[i] = ppf & ~M4K;
        m_acc[i] = acc;  m_msk[i] = msk; seen[i] = a;
        if (msk > M4K) m_flag = 1'b1;
        chk("R5 flag after fill", {31'd0, large_pg}, {31'd0, m_flag});
    endtask

    task automatic lookup(input string tag, input logic [31:0] a, input logic [3:0] len);
        int i;
        logic eh;
        logic [31:0] m, ep, ea;
        i  = slot_of(a, len);
        m  = m_msk[i];
        eh = m_vld[i] && ((a & ~m) == (m_lpf[i] & ~m));
        ep = eh ? ((m_ppf[i] & ~m) | (a & m)) : 32'd0;
        ea = eh ? m_acc[i] : 32'd0;
        drive(3'd0, a, len, 32'd0, 32'd0, 32'd0);
        chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " hit"}, {31'd0, rsp_hit}, {31'd0, eh});
        chk({tag, " paddr"}, rsp_paddr, ep);
        chk({tag, " access"}, rsp_access, ea);
    endtask

    task automatic wait_sweep(input string tag);
        int cnt = 0;
        while (busy && cnt < N + 5) begin
            cnt++;
            @(negedge clk);
        end
        chk({"R10 busy length ", tag}, cnt, N);
    endtask

    task automatic flush_all;
        drive(3'd2, 32'd0, 4'd0, 32'd0, 32'd0, 32'd0);
        wait_sweep("flush-all");
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_flag = 1'b0;
        chk("R6 flag after flush-all", {31'd0, large_pg}, 32'd0);
    endtask

    task automatic flush_ng;
        logic [31:0] orm = 32'd0;
        drive(3'd3, 32'd0, 4'd0, 32'd0, 32'd0, 32'd0);
        wait_sweep("flush-ng");
        for (int i = 0; i < N; i++) begin
            if (m_vld[i]) begin
                if (!m_acc[i][31]) m_vld[i] = 1'b0;
                else orm |= m_msk[i];
            end
        end
        m_flag = (orm > M4K);
        chk("R7 flag after flush-ng", {31'd0, large_pg}, {31'd0, m_flag});
    endtask

    task automatic inv_page(input logic [31:0] a);
        logic [31:0] orm = 32'd0;
        int i;
        if (m_flag) begin
            drive(3'd4, a, 4'd0, 32'd0, 32'd0, 32'd0);
            wait_sweep("invalidate");
            for (int k = 0; k < N; k++) begin
                if (m_vld[k]) begin
                    if ((a & ~m_msk[k]) == (m_lpf[k] & ~m_msk[k])) m_vld[k] = 1'b0;
                    else orm |= m_msk[k];
                end
            end
            m_flag = (orm > M4K);
            chk("R8 flag after masked sweep", {31'd0, large_pg}, {31'd0, m_flag});
        end else begin
            drive(3'd4, a, 4'd0, 32'd0, 32'd0, 32'd0);
            chk("R9 no busy on probe", {31'd0, busy}, 32'd0);
            i = slot_of(a, 4'd0);
            if (m_vld[i] && (m_lpf[i][31:12] == a[31:12])) m_vld[i] = 1'b0;
            chk("R9 flag unchanged", {31'd0, large_pg}, 32'd0);
        end
    endtask

    task automatic check_slots(input string tag);
        for (int i = 0; i < N; i++) lookup(tag, seen[i], 4'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] accs [4];
        accs[0] = 32'h04; accs[1] = 32'h08; accs[2] = 32'h10; accs[3] = 32'h20;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_lpf[i] = '0; m_ppf[i] = '0; m_acc[i] = '0; m_msk[i] = M4K;
            seen[i] = 32'h0040_0000 + (i << 12);
        end
        m_flag = 1'b0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_laddr = '0; req_len = '0;
        req_ppf = '0; req_access = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10 busy after reset", {31'd0, busy}, 32'd0);
        chk("R5 flag after reset", {31'd0, large_pg}, 32'd0);
        chk("R3 no response after reset", {31'd0, rsp_valid}, 32'd0);

        // R3: empty array misses everywhere
        check_slots("R3 empty");

        // R2/R3/R4: fill every slot with a 4 KB page, vary access encodings
        for (int i = 0; i < N; i++)
            fill(32'h0040_0000 + (i << 12), 4'd0, 32'h8000_0000 + ((i * 7) << 12),
                 accs[i % 4] | accs[(i + 1) % 4], M4K);
        for (int i = 0; i < N; i++) begin
            lookup("R3 hit base", 32'h0040_0000 + (i << 12), 4'd0);
            lookup("R4 hit offset", 32'h0040_0000 + (i << 12) + 32'h7FF, 4'd0);
            lookup("R3 other frame same slot", 32'h0050_0000 + (i << 12), 4'd0);
        end

        // R1: length carries into the next slot
        lookup("R1 cross page", 32'h0040_0FFF, 4'd1);
        fill(32'h0050_0FFC, 4'd8, 32'h1234_5000, 32'h3C, M4K);
        lookup("R1 len-indexed hit", 32'h0050_0FFC, 4'd8);
        lookup("R1 slot0 unchanged", 32'h0040_0000, 4'd0);

        // R2: collision overwrite
        fill(32'h0060_3000, 4'd0, 32'h0AAA_A000, 32'h14, M4K);
        lookup("R2 old entry gone", 32'h0040_3000, 4'd0);
        lookup("R2 new entry hits", 32'h0060_3ABC, 4'd0);
        seen[3] = 32'h0060_3000;

        // R9: single-slot probe
        inv_page(32'h0040_5123);
        lookup("R9 probed slot cleared", 32'h0040_5000, 4'd0);
        inv_page(32'h0070_6000);
        lookup("R9 non-matching frame kept", 32'h0040_6000, 4'd0);

        // R7: global 4 KB entries survive, flag stays clear
        fill(32'h0040_7000, 4'd0, 32'h0777_7000, GLB | 32'h10, M4K);
        fill(32'h0040_8000, 4'd0, 32'h0888_8000, GLB | 32'h20, M4K);
        flush_ng();
        check_slots("R7 after flush-ng");

        // R5: large page sets the flag
        fill(32'h0140_0000, 4'd0, 32'h0AC0_0000, GLB | 32'h04, M4M);
        seen[0] = 32'h0140_0000;
        lookup("R5 large hit base", 32'h0140_0000, 4'd0);
        lookup("R3 large hit offset", 32'h0140_0ABC, 4'd0);
        for (int i = 1; i < 5; i++)
            fill(32'h0090_0000 + (i << 12), 4'd0, 32'h0300_0000 + (i << 12), 32'h08, M4K);
        fill(32'h017F_F000, 4'd0, 32'h0B00_0000, 32'h08, M4K);
        seen[15] = 32'h017F_F000;
        for (int i = 1; i < 5; i++) seen[i] = 32'h0090_0000 + (i << 12);

        // R7: large global survives, flag stays set
        flush_ng();
        check_slots("R7 large global kept");

        // R8: masked sweep with an unrelated address keeps the large page
        inv_page(32'h0200_0000);
        check_slots("R8 unrelated sweep");

        // R8: address inside the large page removes it and the 4 KB alias
        fill(32'h017F_F000, 4'd0, 32'h0B00_0000, 32'h08, M4K);
        fill(32'h0090_2000, 4'd0, 32'h0302_0000, 32'h08, M4K);
        inv_page(32'h017F_F000);
        check_slots("R8 masked kill");
        chk("R8 flag recomputed clear", {31'd0, large_pg}, 32'd0);

        // R11: requests during a sweep are not accepted
        fill(32'h0090_2000, 4'd0, 32'h0302_0000, 32'h08, M4K);
        @(negedge clk);
        req_op = 3'd2; req_valid = 1'b1;
        @(negedge clk);
        req_op = 3'd0; req_laddr = 32'h0090_2000; req_len = 4'd0;
        @(negedge clk);
        chk("R11 no response while busy", {31'd0, rsp_valid}, 32'd0);
        req_op = 3'd1; req_laddr = 32'h0095_6000; req_ppf = 32'h0444_4000;
        req_access = 32'h04; req_mask = M4K;
        repeat (2) @(negedge clk);
        chk("R11 still busy", {31'd0, busy}, 32'd1);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_flag = 1'b0;
        lookup("R11 fill during sweep dropped", 32'h0095_6000, 4'd0);
        lookup("R6 flushed entry misses", 32'h0090_2000, 4'd0);

        // R11: reserved op code ignored
        fill(32'h0040_9000, 4'd0, 32'h0999_9000, 32'h20, M4K);
        drive(3'd6, 32'h0040_9000, 4'd0, 32'd0, 32'd0, 32'd0);
        chk("R11 reserved op no busy", {31'd0, busy}, 32'd0);
        chk("R11 reserved op no rsp", {31'd0, rsp_valid}, 32'd0);
        lookup("R11 entry intact", 32'h0040_9000, 4'd0);

        // R6: flush-all with a large page present
        fill(32'h0140_0000, 4'd0, 32'h0AC0_0000, GLB, M4M);
        flush_all();
        seen[0] = 32'h0140_0000; seen[9] = 32'h0040_9000;
        check_slots("R6 after flush-all");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule